// File: doc/BRIEF.md
# ATA device status and interrupt controller

This block sits on the device side of a parallel ATA style register interface. It owns the eight-bit status word and decides, cycle by cycle, what the host sees in it. It tracks the busy condition through hardware reset, soft reset, command acceptance, sector-by-sector data handoff and command completion. It raises the interrupt line when a command ends and drops it when the host reads status. It is the only source of the value the host gets back from any task-file read while the device is busy.

The host side is a plain register bus: one-cycle read and write strobes with a three-bit register index, and a combinational read-data return. There is no valid/ready handshake and no back-pressure, because every register access completes in the cycle it is presented. The register contents other than status (data word, sector count, LBA bytes and so on) live outside this block and arrive on `tf_rdata`. A separate command engine is told about accepted commands through `cmd_go` and `cmd_code`, and about finished sector handoffs through `sect_done`. It answers with sector-ready and done events that carry error, fault and corrected-data flags. The engine, the media and the data path are not part of this block.

Top module: `ata_status_ctrl`

## Requirements
- R1: The status word has, from bit 7 down to bit 0: BSY, DRDY, DF, DSC, DRQ, CORR, a constant 0, ERR. A read at register index 7 returns it zero-extended to 16 bits.
- R2: Releasing `rst_n` sets BSY with every other status bit 0 and INTRQ low. A device-control write with `dctl_srst`=1 does the same. The reset process does not advance while the soft-reset bit stays written as 1. Once it advances, BSY clears on `rst_done` or after RST_TIMEOUT cycles, whichever comes first.
- R3: DRDY and DSC are 0 during reset. Outside reset they follow `spin_ready`, delayed by one cycle.
- R4: A command write (index 7) while BSY=0 and `spin_ready`=1 does the following: it sets BSY, clears ERR, DF, CORR, DRQ and INTRQ, and pulses `cmd_go` for one cycle with `cmd_code` holding the written byte.
- R5: A command write while BSY=0 and `spin_ready`=0 is refused. `cmd_go` stays low, BSY stays 0, DRDY reads 0 and ERR is set. INTRQ rises unless interrupts are disabled.
- R6: A sector-ready event during a busy command clears BSY and sets DRQ. BSY and DRQ are never 1 together.
- R7: While DRQ=1, every read or write at index 0 counts one 16-bit word. The first 255 words leave DRQ set. The access that completes the sector (SECTOR_BYTES/WORD_BYTES words, 256 by default) clears DRQ, sets BSY and pulses `sect_done` in the next cycle.
- R8: A done event during a busy command clears BSY and DRQ, and latches ERR, DF and CORR from `eng_err`, `eng_df` and `eng_corr`.
- R9: Command completion raises INTRQ when the device-control interrupt-disable bit `dctl_nien` was last written 0. When that bit was last written 1, INTRQ stays low.
- R10: A host read at index 7 clears a pending INTRQ. Reads at other indices leave it unchanged.
- R11: While BSY=1, a read at any index returns the status word. While BSY=0, indices 0 to 6 return `tf_rdata`.
- R12: Host writes at any index while BSY=1 are ignored: there is no `cmd_go` and `cmd_code` keeps its value. `proto_viol` is high during such a write strobe and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_rd | input | 1 | Host register read strobe |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Task-file register index (0 data, 7 status/command) |
| host_wdata | input | 8 | Host write byte (command code at index 7) |
| tf_rdata | input | 16 | Contents of the addressed register held outside this block |
| host_rdata | output | 16 | Read data returned to the host |
| dctl_wr | input | 1 | Device-control register write strobe |
| dctl_srst | input | 1 | Soft-reset bit of the device-control write |
| dctl_nien | input | 1 | Interrupt-disable bit of the device-control write |
| spin_ready | input | 1 | Spindle at speed and heads settled |
| rst_done | input | 1 | Reset process finished |
| eng_sect_ready | input | 1 | Engine has the next sector ready for transfer |
| eng_done | input | 1 | Engine finished the command |
| eng_err | input | 1 | Command ended in error (valid with eng_done) |
| eng_df | input | 1 | Device fault seen (valid with eng_done) |
| eng_corr | input | 1 | Data was corrected (valid with eng_done) |
| intrq | output | 1 | Interrupt request to the host |
| proto_viol | output | 1 | Host wrote a register while busy |
| cmd_go | output | 1 | One-cycle pulse: command accepted |
| cmd_code | output | 8 | Last accepted command code |
| sect_done | output | 1 | One-cycle pulse: a full sector was moved |

## Verification
Most state faults in this block surface on the status word within one clock. A stuck busy flag shows as status 0x80 or 0xD0 on the first read after the event that should have cleared it, and it also hides the task file behind the status word. A word counter that is off by one moves the DRQ-to-BSY change of a sector by exactly one data access. The bench therefore reads status just before and just after the sector boundary. An interrupt latch that sets or clears on the wrong event appears on `intrq` at the negedge after the posedge that should have changed it, and each completion and each status read is checked there.

// File: rtl/ata_status_pkg.sv
package ata_status_pkg;

  // status bit order is visible to host software, so it is fixed
  typedef struct packed {
    logic bsy;
    logic drdy;
    logic df;
    logic dsc;
    logic drq;
    logic corr;
    logic zero;
    logic err;
  } status_t;

  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_CMD  = 3'd7;

endpackage

// File: rtl/ata_rst_seq.sv
module ata_rst_seq #(
  parameter int RST_TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_req,
  input  logic srst_hold,
  input  logic rst_done,
  output logic in_reset
);
  localparam int TW = $clog2(RST_TIMEOUT + 1);
  localparam logic [TW-1:0] TLAST = TW'(RST_TIMEOUT - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset <= 1'b1;
      tmr      <= '0;
    end else if (srst_req) begin
      in_reset <= 1'b1;
      tmr      <= '0;
    end else if (in_reset && !srst_hold) begin
      if (rst_done || tmr == TLAST) begin
        in_reset <= 1'b0;
        tmr      <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ata_xfer_cnt.sv
module ata_xfer_cnt #(
  parameter int WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] CLAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt;

  assign last = step && (cnt == CLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (last)    cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ata_intr.sv
module ata_intr (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic raise,
  input  logic ack,
  output logic intrq
);
  // flush beats raise, raise beats acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      intrq <= 1'b0;
    else if (flush)  intrq <= 1'b0;
    else if (raise)  intrq <= 1'b1;
    else if (ack)    intrq <= 1'b0;
  end
endmodule

// File: rtl/ata_status_ctrl.sv
module ata_status_ctrl
  import ata_status_pkg::*;
#(
  parameter int RST_TIMEOUT  = 200,
  parameter int SECTOR_BYTES = 512,
  parameter int WORD_BYTES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  input  logic [15:0] tf_rdata,
  output logic [15:0] host_rdata,
  input  logic        dctl_wr,
  input  logic        dctl_srst,
  input  logic        dctl_nien,
  input  logic        spin_ready,
  input  logic        rst_done,
  input  logic        eng_sect_ready,
  input  logic        eng_done,
  input  logic        eng_err,
  input  logic        eng_df,
  input  logic        eng_corr,
  output logic        intrq,
  output logic        proto_viol,
  output logic        cmd_go,
  output logic [7:0]  cmd_code,
  output logic        sect_done
);
  localparam int WORDS = SECTOR_BYTES / WORD_BYTES;

  logic    in_reset, srst_q, nien_q;
  logic    cmd_bsy, cmd_act, drq_r, err_r, df_r, corr_r, rdy_r;
  logic    bsy, srst_req, cmd_wr, accept, reject;
  logic    data_acc, sect_rdy_ev, done_ev, sect_last, cnt_clr;
  logic    irq_flush, irq_raise, irq_ack;
  status_t sts;

  assign srst_req    = dctl_wr && dctl_srst;
  assign bsy         = in_reset || cmd_bsy;
  assign proto_viol  = host_wr && bsy;
  assign cmd_wr      = host_wr && !bsy && (host_addr == REG_CMD);
  assign accept      = cmd_wr && spin_ready;
  assign reject      = cmd_wr && !spin_ready;
  assign data_acc    = drq_r && !bsy && (host_rd || host_wr) && (host_addr == REG_DATA);
  assign sect_rdy_ev = eng_sect_ready && cmd_bsy && cmd_act && !in_reset;
  assign done_ev     = eng_done && cmd_bsy && cmd_act && !in_reset && !sect_rdy_ev;
  assign cnt_clr     = in_reset || srst_req || cmd_wr || sect_rdy_ev;

  ata_rst_seq #(.RST_TIMEOUT(RST_TIMEOUT)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_req  (srst_req),
    .srst_hold (srst_q),
    .rst_done  (rst_done),
    .in_reset  (in_reset)
  );

  ata_xfer_cnt #(.WORDS(WORDS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .step  (data_acc),
    .last  (sect_last)
  );

  assign irq_flush = in_reset || srst_req || accept;
  assign irq_raise = (done_ev || reject) && !nien_q;
  assign irq_ack   = host_rd && (host_addr == REG_CMD);

  ata_intr u_intr (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (irq_flush),
    .raise (irq_raise),
    .ack   (irq_ack),
    .intrq (intrq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q    <= 1'b0;
      nien_q    <= 1'b0;
      cmd_bsy   <= 1'b0;
      cmd_act   <= 1'b0;
      drq_r     <= 1'b0;
      err_r     <= 1'b0;
      df_r      <= 1'b0;
      corr_r    <= 1'b0;
      rdy_r     <= 1'b0;
      cmd_go    <= 1'b0;
      cmd_code  <= '0;
      sect_done <= 1'b0;
    end else begin
      cmd_go    <= 1'b0;
      sect_done <= 1'b0;
      rdy_r     <= spin_ready && !in_reset && !srst_req;
      if (dctl_wr) begin
        srst_q <= dctl_srst;
        nien_q <= dctl_nien;
      end
      if (in_reset || srst_req) begin
        cmd_bsy <= 1'b0;
        cmd_act <= 1'b0;
        drq_r   <= 1'b0;
        err_r   <= 1'b0;
        df_r    <= 1'b0;
        corr_r  <= 1'b0;
      end else if (accept) begin
        cmd_bsy  <= 1'b1;
        cmd_act  <= 1'b1;
        drq_r    <= 1'b0;
        err_r    <= 1'b0;
        df_r     <= 1'b0;
        corr_r   <= 1'b0;
        cmd_go   <= 1'b1;
        cmd_code <= host_wdata;
      end else if (reject) begin
        cmd_act <= 1'b0;
        drq_r   <= 1'b0;
        err_r   <= 1'b1;
        df_r    <= 1'b0;
        corr_r  <= 1'b0;
      end else if (sect_rdy_ev) begin
        cmd_bsy <= 1'b0;
        drq_r   <= 1'b1;
      end else if (done_ev) begin
        cmd_bsy <= 1'b0;
        cmd_act <= 1'b0;
        drq_r   <= 1'b0;
        err_r   <= eng_err;
        df_r    <= eng_df;
        corr_r  <= eng_corr;
      end else if (sect_last) begin
        drq_r     <= 1'b0;
        cmd_bsy   <= 1'b1;
        sect_done <= 1'b1;
      end
    end
  end

  always_comb begin
    sts.bsy  = bsy;
    sts.drdy = rdy_r;
    sts.df   = df_r;
    sts.dsc  = rdy_r;
    sts.drq  = drq_r;
    sts.corr = corr_r;
    sts.zero = 1'b0;
    sts.err  = err_r;
  end

  assign host_rdata = (bsy || host_addr == REG_CMD) ? {8'h00, sts} : tf_rdata;

endmodule

// File: rtl/ata_status_chk.sv
module ata_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_rd,
  input logic        host_wr,
  input logic [2:0]  host_addr,
  input logic [15:0] host_rdata,
  input logic        dctl_wr,
  input logic        dctl_srst,
  input logic        eng_done,
  input logic        intrq,
  input logic        proto_viol,
  input logic        cmd_go,
  input logic [7:0]  sts
);
  // R6
  bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts[7] && sts[3]));

  // R1
  sts_read_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7) |-> (host_rdata[15:8] == 8'h00 && host_rdata[1] == 1'b0));

  // R11
  busy_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sts[7]) |-> (host_rdata == {8'h00, sts}));

  // R10
  sts_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7 && !eng_done && !host_wr) |=> !intrq);

  // R12
  busy_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sts[7]) |-> proto_viol);

  // R12
  no_write_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |-> !proto_viol);

  // R12
  busy_write_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sts[7]) |=> !cmd_go);

  // R2
  srst_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dctl_wr && dctl_srst) |=> (sts == 8'h80 && !intrq));
endmodule

bind ata_status_ctrl ata_status_chk i_status_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .dctl_wr    (dctl_wr),
  .dctl_srst  (dctl_srst),
  .eng_done   (eng_done),
  .intrq      (intrq),
  .proto_viol (proto_viol),
  .cmd_go     (cmd_go),
  .sts        (sts)
);

// File: tb/test_ata_status_ctrl.sv
`timescale 1ns/1ps
module test_ata_status_ctrl;
  localparam int TMO = 40;
  localparam logic [15:0] TF = 16'h1234;

  // [20:13] cmd, [12] err, [11] df, [10] corr, [9] nien, [8:1] status, [0] intrq
  localparam logic [20:0] VEC [6] = '{
    {8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 8'h50, 1'b1},
    {8'h30, 1'b1, 1'b0, 1'b0, 1'b0, 8'h51, 1'b1},
    {8'hEC, 1'b0, 1'b1, 1'b0, 1'b1, 8'h70, 1'b0},
    {8'hC8, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55, 1'b1},
    {8'hE7, 1'b1, 1'b1, 1'b1, 1'b1, 8'h75, 1'b0},
    {8'h90, 1'b0, 1'b0, 1'b1, 1'b0, 8'h54, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, host_rd, host_wr, dctl_wr, dctl_srst, dctl_nien;
  logic spin_ready, rst_done, eng_sect_ready, eng_done, eng_err, eng_df, eng_corr;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata, cmd_code;
  logic [15:0] tf_rdata, host_rdata;
  logic intrq, proto_viol, cmd_go, sect_done;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  ata_status_ctrl #(.RST_TIMEOUT(TMO)) i_ata_status_ctrl (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .tf_rdata(tf_rdata),
    .host_rdata(host_rdata), .dctl_wr(dctl_wr), .dctl_srst(dctl_srst),
    .dctl_nien(dctl_nien), .spin_ready(spin_ready), .rst_done(rst_done),
    .eng_sect_ready(eng_sect_ready), .eng_done(eng_done), .eng_err(eng_err),
    .eng_df(eng_df), .eng_corr(eng_corr), .intrq(intrq), .proto_viol(proto_viol),
    .cmd_go(cmd_go), .cmd_code(cmd_code), .sect_done(sect_done)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // all bus tasks start and end at a negedge
  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] v, output logic viol);
    host_addr = a; host_wdata = v; host_wr = 1'b1;
    #1 viol = proto_viol;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic dctl(input logic s, input logic n);
    dctl_srst = s; dctl_nien = n; dctl_wr = 1'b1;
    @(negedge clk); dctl_wr = 1'b0;
  endtask

  task automatic fin(input logic e, input logic f, input logic c);
    eng_err = e; eng_df = f; eng_corr = c; eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic sect_rdy();
    eng_sect_ready = 1'b1;
    @(negedge clk); eng_sect_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic v;
    rst_n = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    tf_rdata = TF; dctl_wr = 0; dctl_srst = 0; dctl_nien = 0; spin_ready = 0;
    rst_done = 0; eng_sect_ready = 0; eng_done = 0; eng_err = 0; eng_df = 0; eng_corr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset state, R11 redirect during reset
    bus_rd(3'd7, d); chk(d, 16'h0080, "R2 status after reset release");
    bus_rd(3'd3, d); chk(d, 16'h0080, "R11 redirect while resetting");
    chk({15'd0, intrq}, 16'd0, "R2 intrq low in reset");
    repeat (TMO + 3) @(negedge clk);
    bus_rd(3'd7, d); chk(d, 16'h0000, "R2 timeout ends reset, R3 not ready");
    spin_ready = 1;
    @(negedge clk);
    bus_rd(3'd7, d); chk(d, 16'h0050, "R3 DRDY DSC follow spin_ready");
    bus_rd(3'd3, d); chk(d, TF, "R11 idle read passes task file");

    // table of command completions: R4 R8 R9 R10
    foreach (VEC[i]) begin
      dctl(1'b0, VEC[i][9]);
      bus_wr(3'd7, VEC[i][20:13], v);
      chk({15'd0, v}, 16'd0, "R12 idle write not flagged");
      chk({15'd0, cmd_go}, 16'd1, "R4 cmd_go pulse");
      chk({8'd0, cmd_code}, {8'd0, VEC[i][20:13]}, "R4 cmd_code");
      bus_rd(3'd7, d); chk(d, 16'h00D0, "R4 busy, flags cleared");
      fin(VEC[i][12], VEC[i][11], VEC[i][10]);
      chk({15'd0, intrq}, {15'd0, VEC[i][0]}, "R9 intrq at completion");
      bus_rd(3'd1, d); chk(d, TF, "R11 idle read other register");
      chk({15'd0, intrq}, {15'd0, VEC[i][0]}, "R10 other read keeps intrq");
      bus_rd(3'd7, d); chk(d, {8'h00, VEC[i][8:1]}, "R8 R1 completion status");
      chk({15'd0, intrq}, 16'd0, "R10 status read clears intrq");
    end

    // R12 writes ignored while busy
    dctl(1'b0, 1'b0);
    bus_wr(3'd7, 8'hC4, v);
    bus_wr(3'd2, 8'h55, v); chk({15'd0, v}, 16'd1, "R12 busy write flagged");
    bus_wr(3'd7, 8'h99, v); chk({15'd0, v}, 16'd1, "R12 busy command flagged");
    chk({15'd0, cmd_go}, 16'd0, "R12 busy command no cmd_go");
    chk({8'd0, cmd_code}, 16'h00C4, "R12 cmd_code unchanged");
    fin(1'b0, 1'b0, 1'b0);
    bus_rd(3'd7, d); chk(d, 16'h0050, "R8 completion after ignored writes");

    // R6 R7 sector handoff, read direction
    bus_wr(3'd7, 8'h20, v);
    sect_rdy();
    bus_rd(3'd7, d); chk(d, 16'h0058, "R6 DRQ set, BSY clear");
    for (int k = 0; k < 255; k++) bus_rd(3'd0, d);
    chk(d, TF, "R11 data read while DRQ");
    bus_rd(3'd7, d); chk(d, 16'h0058, "R7 DRQ held after 255 words");
    bus_rd(3'd0, d);
    chk({15'd0, sect_done}, 16'd1, "R7 sect_done after 256th word");
    bus_rd(3'd7, d); chk(d, 16'h00D0, "R7 BSY after full sector");
    bus_rd(3'd3, d); chk(d, 16'h00D0, "R11 redirect between sectors");
    // write direction
    sect_rdy();
    bus_wr(3'd0, 8'hA5, v); chk({15'd0, v}, 16'd0, "R12 data write during DRQ not flagged");
    for (int k = 1; k < 256; k++) bus_wr(3'd0, 8'hA5, v);
    bus_rd(3'd7, d); chk(d, 16'h00D0, "R7 BSY after written sector");
    fin(1'b0, 1'b0, 1'b0);
    chk({15'd0, intrq}, 16'd1, "R9 intrq after transfer command");
    bus_rd(3'd7, d); chk(d, 16'h0050, "R8 status after transfer command");

    // R5 not-ready refusal
    spin_ready = 0;
    @(negedge clk);
    bus_wr(3'd7, 8'h20, v);
    chk({15'd0, cmd_go}, 16'd0, "R5 refused command no cmd_go");
    chk({15'd0, intrq}, 16'd1, "R5 refusal raises intrq");
    bus_rd(3'd7, d); chk(d, 16'h0001, "R5 refusal status");
    spin_ready = 1;
    @(negedge clk);

    // R2 soft reset held, then released
    bus_wr(3'd7, 8'h30, v);
    dctl(1'b1, 1'b0);
    bus_rd(3'd7, d); chk(d, 16'h0080, "R2 soft reset status");
    repeat (TMO + 5) @(negedge clk);
    bus_rd(3'd7, d); chk(d, 16'h0080, "R2 reset held while SRST set");
    dctl(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    bus_rd(3'd7, d); chk(d, 16'h0080, "R2 still busy before rst_done");
    rst_done = 1;
    @(negedge clk); rst_done = 0;
    @(negedge clk);
    bus_rd(3'd7, d); chk(d, 16'h0050, "R2 rst_done ends reset, R3 ready");

    finish_run();
  end
endmodule